// File: doc/BRIEF.md
# Programmable Duty Clock Synthesizer

This block divides a fast system clock down to a slow sensor clock. A single 32-bit configuration word is written through a simple write port. The word sets four things: the number of system cycles spent low, the number spent high, the delay of a one-cycle hold strobe after each rising edge, and an enable. While the block is enabled, the output alternates between a low phase and a high phase. Because each phase has its own length, odd divide ratios come out exact.

The written word can be read back at any time. It is copied into the working settings only at phase boundaries: when the block is idle, or when a high phase finishes. A change made in the middle of a period therefore never shortens or stretches the phase that is under way. Software that wants a ratio R of system clock to output clock computes k = R - 2. It then writes floor((k+1)/2) as the low count and floor(k/2) as the high count, which gives a period of exactly k + 2 system cycles for any R from 2 to 512.

Top module: `duty_clk_synth`

## Requirements
- R1: Word layout. Bits 7:0 hold the low count, bits 15:8 the high count, bits 23:16 the hold count, and bit 24 the enable. `rd_data` returns the last word written, all 32 bits, from the cycle after the capturing edge. Bits 31:25 have no effect on the output.
- R2: While the working enable is clear and the block is idle, `clk_out` and `hold_pulse` stay low.
- R3: A low phase lasts low+1 system cycles and a high phase lasts high+1 system cycles.
- R4: With the encoding k = R - 2, low = floor((k+1)/2) and high = floor(k/2), the output period is k + 2 cycles. This holds at both ends of the range, 2:1 (all zero) and 512:1 (low = high = 255), and for odd ratios.
- R5: A word written during a running period takes effect only at the start of the next low phase. The high phase under way keeps its old length.
- R6: `hold_pulse` is high for exactly one cycle, hold+1 cycles after each rising edge of `clk_out`.
- R7: After reset, `rd_data` is zero and both `clk_out` and `hold_pulse` are low.
- R8: Clearing the enable while running lets the current high phase finish at full length. After that, `clk_out` stays low.
- R9: From idle, an enabling write puts `clk_out` high on the (low+3)-th rising system clock edge after the edge that captures the write.
- R10: If a new rising edge arrives before a pending hold strobe has fired, the delay restarts from the new edge. A hold count longer than the period therefore never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Captures `wr_data` into the configuration word on the rising edge |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Readback of the configuration word |
| clk_out | output | 1 | Synthesized output clock |
| hold_pulse | output | 1 | One-cycle hold strobe |

## Verification
The hardest situation to reach is a write that lands inside a high phase. The bench has to observe that the old high length is kept and that the new low and high lengths appear only in the following period. To get there, the bench watches `clk_out` on falling system edges. It issues the write in the very cycle it first sees the output high, so the capturing edge falls inside a known high phase of at least two cycles. The disable-while-running case and the hold-restart case use the same alignment to the observed rising edge.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  parameter int unsigned PH_W   = 8;
  parameter int unsigned WORD_W = 32;

  // Field positions within the configuration word
  localparam int unsigned LO_LSB   = 0;
  localparam int unsigned HI_LSB   = LO_LSB + PH_W;
  localparam int unsigned HOLD_LSB = HI_LSB + PH_W;
  localparam int unsigned EN_BIT   = HOLD_LSB + PH_W;

  typedef struct packed {
    logic            en;
    logic [PH_W-1:0] hold;
    logic [PH_W-1:0] hi;
    logic [PH_W-1:0] lo;
  } cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.lo   = w[LO_LSB   +: PH_W];
    c.hi   = w[HI_LSB   +: PH_W];
    c.hold = w[HOLD_LSB +: PH_W];
    c.en   = w[EN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dcs_cfg_reg.sv
module dcs_cfg_reg
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              load,
  output logic [WORD_W-1:0] word_q,
  output logic              pend_en,
  output cfg_t              act_q
);
  logic [WORD_W-1:0] word_d;
  cfg_t              act_d;

  // Next-state: written word, and working copy taken on load
  always_comb begin
    word_d = word_q;
    act_d  = act_q;
    if (wr_en) word_d = wr_data;
    if (load)  act_d  = unpack_word(word_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_en) word_q <= word_d;
      if (load)  act_q  <= act_d;
    end
  end

  assign pend_en = word_q[EN_BIT];

  // R5: working settings move only on a boundary load
  p_act_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));

  // R7: word is zero when reset has just released
  p_word_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_q == '0));

  // R1: a write is visible on the readback in the next cycle
  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word_q == $past(wr_data)));
endmodule

// File: rtl/dcs_phase_ctr.sv
module dcs_phase_ctr
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t act,
  input  logic pend_en,
  output logic load,
  output logic rise_nxt,
  output logic clk_out
);
  phase_e          st_q, st_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    load     = 1'b0;
    rise_nxt = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        load = 1'b1;
        if (act.en) begin
          st_d   = PH_LOW;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      PH_LOW: begin
        cnt_en = 1'b1;
        if (cnt_q == act.lo) begin
          st_d     = PH_HIGH;
          cnt_d    = '0;
          rise_nxt = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HIGH: begin
        cnt_en = 1'b1;
        if (cnt_q == act.hi) begin
          load  = 1'b1;
          cnt_d = '0;
          st_d  = pend_en ? PH_LOW : PH_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d   = PH_IDLE;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // Registered state drives the clock: no combinational glitch
  assign clk_out = (st_q == PH_HIGH);

  // R2: idle with enable clear keeps the output low
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && !act.en) |=> !clk_out);

  // R3: rising edge only after a complete low phase
  p_rise_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> ($past(st_q) == PH_LOW && $past(cnt_q) == $past(act.lo)));

  // R3: high phase is not cut short
  p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_HIGH && cnt_q != act.hi) |=> clk_out);

  // R8: falling edge only at the end of a full high phase
  p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> ($past(cnt_q) == $past(act.hi)));
endmodule

// File: rtl/dcs_hold_gen.sv
module dcs_hold_gen
  import dcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PH_W-1:0] hold_val,
  output logic            pulse
);
  logic [PH_W-1:0] hcnt_q, hcnt_d;
  logic [PH_W-1:0] lim_q, lim_d;
  logic            armed_q, armed_d;
  logic            pulse_d;
  logic            hit;

  assign hit = armed_q && (hcnt_q == lim_q);

  always_comb begin
    hcnt_d  = hcnt_q;
    lim_d   = lim_q;
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (start) begin
      // A new rising edge restarts the delay (R10)
      hcnt_d  = '0;
      lim_d   = hold_val;
      armed_d = 1'b1;
    end else if (hit) begin
      pulse_d = 1'b1;
      armed_d = 1'b0;
    end else if (armed_q) begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      lim_q   <= '0;
      armed_q <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      hcnt_q  <= hcnt_d;
      lim_q   <= lim_d;
      armed_q <= armed_d;
      pulse   <= pulse_d;
    end
  end

  // R6: strobe lasts a single cycle
  p_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R6: strobe only from an armed delay
  p_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(armed_q));
endmodule

// File: rtl/duty_clk_synth.sv
module duty_clk_synth
  import dcs_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              clk_out,
  output logic              hold_pulse
);
  logic srst_n;
  logic load;
  logic rise_nxt;
  logic pend_en;
  cfg_t act;

  dcs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dcs_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .load    (load),
    .word_q  (rd_data),
    .pend_en (pend_en),
    .act_q   (act)
  );

  dcs_phase_ctr u_phase (
    .clk      (clk),
    .rst_n    (srst_n),
    .act      (act),
    .pend_en  (pend_en),
    .load     (load),
    .rise_nxt (rise_nxt),
    .clk_out  (clk_out)
  );

  dcs_hold_gen u_hold (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (rise_nxt),
    .hold_val (act.hold),
    .pulse    (hold_pulse)
  );

  // R7: outputs quiet right after reset release
  p_quiet_reset_r7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (!clk_out && !hold_pulse));
endmodule

// File: tb/test_duty_clk_synth.sv
module test_duty_clk_synth;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        clk_out;
  logic        hold_pulse;

  int n_total = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  duty_clk_synth i_duty_clk_synth (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out), .hold_pulse(hold_pulse)
  );

  function automatic logic [31:0] mk(input bit en, input int hold, input int hi, input int lo);
    return {7'd0, en, hold[7:0], hi[7:0], lo[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    while (clk_out !== 1'b0) @(negedge clk);
    while (clk_out !== 1'b1) @(negedge clk);
  endtask

  // Counts consecutive samples at level lvl, starting at the current one
  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (clk_out === lvl) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_data == 0, "R7 rd_data", rd_data, 0);
    chk(clk_out == 0 && hold_pulse == 0, "R7 outputs", {clk_out, hold_pulse}, 0);
  endtask

  task automatic t_readback_disabled();
    int seen = 0;
    write_cfg(32'hFE00_5A3C);
    chk(rd_data == 32'hFE00_5A3C, "R1 readback", rd_data, 32'hFE00_5A3C);
    repeat (20) begin
      @(negedge clk);
      if (clk_out || hold_pulse) seen++;
    end
    chk(seen == 0, "R2 stays low with enable clear", seen, 0);
  endtask

  task automatic t_enable_latency();
    int idx = 0;
    @(negedge clk); wr_en = 1'b1; wr_data = mk(1, 1, 3, 4);
    while (clk_out !== 1'b1 && idx < 100) begin
      @(negedge clk); idx++; wr_en = 1'b0;
    end
    chk(idx == 4 + 4, "R9 first rise sample index", idx, 8);
  endtask

  task automatic t_period(input int lo, input int hi, input string req);
    int nh, nl;
    write_cfg(mk(1, 0, hi, lo));
    wait_rise(); wait_rise();
    count_level(1'b1, nh);
    count_level(1'b0, nl);
    chk(nh == hi + 1, {req, " high length"}, nh, hi + 1);
    chk(nl == lo + 1, {req, " low length"}, nl, lo + 1);
  endtask

  task automatic t_ratio(input int r);
    int k = r - 2;
    int nh, nl;
    write_cfg(mk(1, 0, k / 2, (k + 1) / 2));
    wait_rise(); wait_rise();
    count_level(1'b1, nh);
    count_level(1'b0, nl);
    chk(nh + nl == r, "R4 period", nh + nl, r);
  endtask

  task automatic t_hold(input int lo, input int hi, input int hold);
    int n = 0;
    write_cfg(mk(1, hold, hi, lo));
    wait_rise(); wait_rise();
    while (!hold_pulse && n < 600) begin @(negedge clk); n++; end
    chk(n == hold + 1, "R6 hold delay", n, hold + 1);
    @(negedge clk);
    chk(hold_pulse == 0, "R6 strobe width", hold_pulse, 0);
  endtask

  task automatic t_hold_restart();
    int cnt = 0;
    write_cfg(mk(1, 10, 1, 1));
    wait_rise(); wait_rise();
    repeat (40) begin
      @(negedge clk);
      if (hold_pulse) cnt++;
    end
    chk(cnt == 0, "R10 restarted strobe never fires", cnt, 0);
  endtask

  task automatic t_midperiod_change();
    int nh = 1, n2, nl;
    write_cfg(mk(1, 0, 3, 2));
    wait_rise(); wait_rise();
    wr_en = 1'b1; wr_data = mk(1, 0, 1, 5);
    @(negedge clk); wr_en = 1'b0;
    chk(rd_data == mk(1, 0, 1, 5), "R1 readback during high", rd_data, mk(1, 0, 1, 5));
    count_level(1'b1, n2);
    nh += n2;
    chk(nh == 4, "R5 current high keeps old length", nh, 4);
    count_level(1'b0, nl);
    chk(nl == 6, "R5 new low length", nl, 6);
    count_level(1'b1, n2);
    chk(n2 == 2, "R5 new high length", n2, 2);
  endtask

  task automatic t_disable_running();
    int nh = 1, n2, seen = 0;
    write_cfg(mk(1, 0, 2, 1));
    wait_rise(); wait_rise();
    wr_en = 1'b1; wr_data = mk(0, 0, 2, 1);
    @(negedge clk); wr_en = 1'b0;
    count_level(1'b1, n2);
    nh += n2;
    chk(nh == 3, "R8 last high at full length", nh, 3);
    repeat (30) begin
      @(negedge clk);
      if (clk_out) seen++;
    end
    chk(seen == 0, "R8 output stays low", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    t_reset();
    t_readback_disabled();
    t_disable_running();
    t_enable_latency();
    t_period(4, 3, "R3 odd split");
    t_period(0, 6, "R3 short low");
    t_ratio(2);
    t_ratio(9);
    t_ratio(512);
    t_hold(3, 2, 2);
    t_hold(2, 2, 0);
    t_hold_restart();
    t_midperiod_change();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule